// File: doc/BRIEF.md
# Field Memory Serial Write Port

This block is the write half of a serial-access field store. Bytes arrive on a single write clock together with a field-restart strobe, a write enable and a store (mask) enable. The block keeps a wrapping write pointer and turns each accepted byte into an address, data and strobe for a dual-port storage array that sits outside the block.

The two enables act differently. Dropping the write enable freezes the pointer and accepts nothing. Dropping the store enable while the write enable stays high still advances the pointer, but the addressed location keeps its old contents. This allows selective overwrite, for example to insert a small picture into a larger one.

Each accepted byte is parked in a one-entry holding stage. It reaches the array only on the next accepted cycle or on the next field restart. The array write therefore lags the input by at least one clock, which lets a downstream device take the read stream of an upstream one with no glue. The restart is also the point that commits the last byte of a field.

Two status outputs let a system monitor the sequencing rules:
- an active-cycle count, used to check the minimum field length;
- a flag that reports a restart strobe which was low for too short a time before it rose again.

Top module: `fmw_write_port`

## Requirements
- R1: A rising edge of `clk` that samples `wr_rst_i` high while the previous edge sampled it low is a restart. A restart sets `ptr_o` to 0 and captures no byte, whatever `wr_en_i` and `in_en_i` are.
- R2: Further edges that sample `wr_rst_i` still high keep `ptr_o` at 0. They capture nothing and issue no array strobe.
- R3: An edge with `wr_rst_i` low and `wr_en_i` high captures `din_i` at address `ptr_o` and advances `ptr_o` by one.
- R4: An edge with `wr_rst_i` and `wr_en_i` both low leaves `ptr_o` unchanged and gives `mem_we_o` low after it.
- R5: An edge with `wr_en_i` high and `in_en_i` low advances `ptr_o`, but no array write is ever issued for that address in that cycle.
- R6: A captured byte is written on the next edge that is either an accepted cycle (`wr_en_i` high, no restart) or a restart. After that edge, `mem_we_o` is high for one cycle with the byte's address and data.
- R7: The last byte captured before a restart is committed to the array by that restart edge.
- R8: `ptr_o` wraps from DEPTH-1 to 0 on an accepted cycle.
- R9: `gap_viol_o` pulses for one cycle after a restart when fewer than MIN_GAP edges sampled `wr_rst_i` low since it was last high. The first restart after block reset never flags.
- R10: `act_cnt_o` counts accepted cycles since the last restart. It saturates at 2^CNT_W-1 and reads 0 after any edge that samples `wr_rst_i` high.
- R11: Synchronous `rst` drives `ptr_o`, `act_cnt_o`, `mem_we_o`, `mem_addr_o`, `mem_data_o` and `gap_viol_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge active |
| rst | input | 1 | Synchronous active-high block reset |
| wr_rst_i | input | 1 | Field restart strobe |
| wr_en_i | input | 1 | Accept byte and advance pointer |
| in_en_i | input | 1 | Store enable; low masks the write |
| din_i | input | DATA_W | Serial input byte |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_data_o | output | DATA_W | Array write data |
| ptr_o | output | ADDR_W | Current write pointer |
| act_cnt_o | output | CNT_W | Accepted cycles since last restart |
| gap_viol_o | output | 1 | Restart-gap violation pulse |

## Verification
The bench builds the block with DEPTH=12 and CNT_W=5.

A depth that is not a power of two selects the compare-based wrap path. It also lets a field of about a dozen bytes cross the wrap point. The narrow count reaches saturation within a few dozen accepted cycles.

MIN_GAP stays at 2, so a restart preceded by a single low edge shows the violation case. A restart preceded by exactly two low edges shows the boundary.

// File: rtl/fmw_pkg.sv
package fmw_pkg;

    // Classification of one write-clock edge
    typedef enum logic [2:0] {
        K_IDLE      = 3'd0,   // no restart, write enable low
        K_STORE     = 3'd1,   // accepted and stored
        K_SKIP      = 3'd2,   // accepted, store masked
        K_RST_FIRST = 3'd3,   // first edge of a restart
        K_RST_HELD  = 3'd4    // restart strobe still high
    } cyc_kind_e;

    function automatic cyc_kind_e classify(input logic rs_now, input logic rs_prev,
                                           input logic we, input logic ie);
        cyc_kind_e k;
        if (rs_now)
            k = rs_prev ? K_RST_HELD : K_RST_FIRST;
        else if (!we)
            k = K_IDLE;
        else
            k = ie ? K_STORE : K_SKIP;
        return k;
    endfunction

    function automatic logic is_accept(input cyc_kind_e k);
        return (k == K_STORE) || (k == K_SKIP);
    endfunction

    function automatic logic is_restart(input cyc_kind_e k);
        return (k == K_RST_FIRST) || (k == K_RST_HELD);
    endfunction

endpackage

// File: rtl/fmw_ctrl.sv
module fmw_ctrl
    import fmw_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_rst_i,
    input  logic              wr_en_i,
    input  logic              in_en_i,
    output cyc_kind_e         kind_o,
    output logic [ADDR_W-1:0] ptr_o
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic              rs_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ptr_nxt;
    cyc_kind_e         kind;

    assign kind = classify(wr_rst_i, rs_q, wr_en_i, in_en_i);

    generate
        if (DEPTH == (1 << ADDR_W)) begin : g_pow2
            assign ptr_nxt = ptr_q + 1'b1;
        end else begin : g_cmp
            assign ptr_nxt = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_q  <= 1'b0;
            ptr_q <= '0;
        end else begin
            rs_q <= wr_rst_i;
            if (is_restart(kind))
                ptr_q <= '0;
            else if (is_accept(kind))
                ptr_q <= ptr_nxt;
        end
    end

    assign kind_o = kind;
    assign ptr_o  = ptr_q;

endmodule

// File: rtl/fmw_stage.sv
module fmw_stage
    import fmw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  cyc_kind_e         kind_i,
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [DATA_W-1:0] din_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } entry_t;

    entry_t hold_q;
    entry_t out_q;
    logic   flush;

    // the parked entry leaves on an accepted cycle or on the first restart edge
    assign flush = hold_q.valid && (is_accept(kind_i) || (kind_i == K_RST_FIRST));

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            out_q  <= '0;
        end else begin
            out_q.valid <= 1'b0;
            if (flush)
                out_q <= hold_q;
            if (is_accept(kind_i)) begin
                hold_q.valid <= (kind_i == K_STORE);
                hold_q.addr  <= ptr_i;
                hold_q.data  <= din_i;
            end else if (kind_i == K_RST_FIRST) begin
                hold_q.valid <= 1'b0;
            end
        end
    end

    assign mem_we_o   = out_q.valid;
    assign mem_addr_o = out_q.addr;
    assign mem_data_o = out_q.data;

endmodule

// File: rtl/fmw_mon.sv
module fmw_mon
    import fmw_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MIN_GAP = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  cyc_kind_e        kind_i,
    output logic [CNT_W-1:0] act_cnt_o,
    output logic             gap_viol_o
);

    localparam int              GW      = (MIN_GAP < 2) ? 1 : $clog2(MIN_GAP + 1);
    localparam logic [GW-1:0]   GAP_LIM = GW'(MIN_GAP);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [GW-1:0]    low_q;
    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic             viol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q   <= '0;
            armed_q <= 1'b0;
            cnt_q   <= '0;
            viol_q  <= 1'b0;
        end else begin
            viol_q <= 1'b0;
            if (is_restart(kind_i)) begin
                low_q <= '0;
                cnt_q <= '0;
                if (kind_i == K_RST_FIRST) begin
                    viol_q  <= armed_q && (low_q < GAP_LIM);
                    armed_q <= 1'b1;
                end
            end else begin
                if (low_q < GAP_LIM)
                    low_q <= low_q + 1'b1;
                if (is_accept(kind_i) && (cnt_q != CNT_MAX))
                    cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign act_cnt_o  = cnt_q;
    assign gap_viol_o = viol_q;

endmodule

// File: rtl/fmw_write_port.sv
module fmw_write_port
    import fmw_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 1024,
    parameter int CNT_W   = 16,
    parameter int MIN_GAP = 2,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_rst_i,
    input  logic              wr_en_i,
    input  logic              in_en_i,
    input  logic [DATA_W-1:0] din_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o,
    output logic [ADDR_W-1:0] ptr_o,
    output logic [CNT_W-1:0]  act_cnt_o,
    output logic              gap_viol_o
);

    cyc_kind_e         kind;
    logic [ADDR_W-1:0] ptr;

    fmw_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst(rst), .wr_rst_i(wr_rst_i), .wr_en_i(wr_en_i),
        .in_en_i(in_en_i), .kind_o(kind), .ptr_o(ptr)
    );

    fmw_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_stage (
        .clk(clk), .rst(rst), .kind_i(kind), .ptr_i(ptr), .din_i(din_i),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o)
    );

    fmw_mon #(.CNT_W(CNT_W), .MIN_GAP(MIN_GAP)) u_mon (
        .clk(clk), .rst(rst), .kind_i(kind),
        .act_cnt_o(act_cnt_o), .gap_viol_o(gap_viol_o)
    );

    assign ptr_o = ptr;

endmodule

// File: rtl/fmw_write_port_chk.sv
module fmw_write_port_chk #(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_rst_i,
    input logic              wr_en_i,
    input logic              in_en_i,
    input logic [DATA_W-1:0] din_i,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_data_o,
    input logic [ADDR_W-1:0] ptr_o,
    input logic [CNT_W-1:0]  act_cnt_o,
    input logic              gap_viol_o
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    // R1
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wr_rst_i |=> (ptr_o == '0));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_rst_i && !wr_en_i) |=> ($stable(ptr_o) && !mem_we_o));

    // R8
    advance_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_rst_i && wr_en_i) |=>
            (ptr_o == (($past(ptr_o) == LAST) ? '0 : $past(ptr_o) + 1'b1)));

    // R6
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> ($past(wr_rst_i) || $past(wr_en_i)));

    // R10
    count_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wr_rst_i |=> (act_cnt_o == '0));

    // R9
    gap_cause_chk: assert property (@(posedge clk) disable iff (rst)
        gap_viol_o |-> $past(wr_rst_i));

    // R9
    gap_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        gap_viol_o |=> !gap_viol_o);

endmodule

bind fmw_write_port fmw_write_port_chk #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .wr_rst_i(wr_rst_i), .wr_en_i(wr_en_i),
    .in_en_i(in_en_i), .din_i(din_i), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o), .ptr_o(ptr_o),
    .act_cnt_o(act_cnt_o), .gap_viol_o(gap_viol_o)
);

// File: tb/fmw_write_port_tb_top.sv
module fmw_write_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW      = 8;
    localparam int DEPTH   = 12;
    localparam int CNT_W   = 5;
    localparam int MIN_GAP = 2;
    localparam int AW      = $clog2(DEPTH);
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_rst_i = 1'b0, wr_en_i = 1'b0, in_en_i = 1'b0;
    logic [DW-1:0] din_i = '0;
    logic          mem_we_o;
    logic [AW-1:0] mem_addr_o, ptr_o;
    logic [DW-1:0] mem_data_o;
    logic [CNT_W-1:0] act_cnt_o;
    logic          gap_viol_o;

    fmw_write_port #(.DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CNT_W), .MIN_GAP(MIN_GAP)) dut_i (
        .clk(clk), .rst(rst), .wr_rst_i(wr_rst_i), .wr_en_i(wr_en_i), .in_en_i(in_en_i),
        .din_i(din_i), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_data_o(mem_data_o), .ptr_o(ptr_o), .act_cnt_o(act_cnt_o),
        .gap_viol_o(gap_viol_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int errors = 0, checks = 0;
    bit finished = 0;

    // behavioural reference state
    int m_ptr = 0, m_cnt = 0, m_low = 0;
    bit m_prev = 0, m_armed = 0;
    bit hold_v = 0; int hold_a = 0, hold_d = 0;   // parked byte
    bit e_we = 0, e_viol = 0; int e_addr = 0, e_data = 0;

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model(input bit r, input bit w, input bit i, input int d);
        e_we = 0; e_viol = 0;
        if (r) begin
            if (!m_prev) begin
                e_viol = m_armed && (m_low < MIN_GAP);
                m_armed = 1;
                if (hold_v) begin e_we = 1; e_addr = hold_a; e_data = hold_d; end
                hold_v = 0;
            end
            m_ptr = 0; m_cnt = 0; m_low = 0;
        end else begin
            if (m_low < MIN_GAP) m_low++;
            if (w) begin
                if (hold_v) begin e_we = 1; e_addr = hold_a; e_data = hold_d; end
                hold_v = i; hold_a = m_ptr; hold_d = d;
                m_ptr = (m_ptr + 1) % DEPTH;
                if (m_cnt < CNT_MAX) m_cnt++;
            end
        end
        m_prev = r;
    endtask

    // one clock: drive at the falling edge, update model at the rising edge, compare at the next falling edge
    task automatic cyc(input bit r, input bit w, input bit i, input int d);
        wr_rst_i = r; wr_en_i = w; in_en_i = i; din_i = DW'(d);
        @(posedge clk);
        model(r, w, i, d);
        @(negedge clk);
        check("R3/R4/R8 pointer", ptr_o, m_ptr);
        check("R6/R7 strobe", mem_we_o, e_we);
        if (e_we) begin
            check("R6 address", mem_addr_o, e_addr);
            check("R6 data", mem_data_o, e_data);
        end
        check("R10 count", act_cnt_o, m_cnt);
        check("R9 gap flag", gap_viol_o, e_viol);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 ptr", ptr_o, 0);
        check("R11 count", act_cnt_o, 0);
        check("R11 strobe", mem_we_o, 0);
        check("R11 addr", mem_addr_o, 0);
        check("R11 data", mem_data_o, 0);
        check("R11 gap", gap_viol_o, 0);
        rst = 1'b0;

        // R1 first restart: enables high yet ignored, no gap flag
        cyc(1, 1, 1, 8'hAA);
        check("R1 ptr after restart", ptr_o, 0);
        check("R1 nothing captured", act_cnt_o, 0);
        check("R9 first restart not flagged", gap_viol_o, 0);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);

        // R3/R8 fourteen accepted bytes cross the wrap
        for (int k = 0; k < 14; k++) cyc(0, 1, 1, 8'h10 + k);
        check("R8 wrapped ptr", ptr_o, 2);
        check("R10 count 14", act_cnt_o, 14);

        // R4 idle edge
        cyc(0, 0, 1, 8'hEE);
        check("R4 ptr held", ptr_o, 2);
        check("R4 no strobe", mem_we_o, 0);

        // R7 restart commits the parked byte
        cyc(1, 0, 0, 0);
        check("R7 flush strobe", mem_we_o, 1);
        check("R7 flush addr", mem_addr_o, 1);
        check("R7 flush data", mem_data_o, 8'h1D);

        // R2 held restart
        cyc(1, 1, 1, 8'h33);
        check("R2 ptr", ptr_o, 0);
        check("R2 no strobe", mem_we_o, 0);
        cyc(1, 1, 1, 8'h34);

        // R9 one low edge before a restart
        cyc(0, 1, 1, 8'h55);
        cyc(1, 0, 0, 0);
        check("R9 short gap flagged", gap_viol_o, 1);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        cyc(1, 0, 0, 0);
        check("R9 two low edges ok", gap_viol_o, 0);
        cyc(0, 0, 0, 0);

        // R5 masked store
        cyc(0, 1, 0, 8'h77);
        check("R5 ptr advances", ptr_o, 1);
        cyc(0, 1, 1, 8'h88);
        check("R5 masked byte not written", mem_we_o, 0);
        cyc(1, 0, 0, 0);
        check("R5 following byte addr", mem_addr_o, 1);
        check("R5 following byte data", mem_data_o, 8'h88);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);

        // R10 saturation
        for (int k = 0; k < 40; k++) cyc(0, 1, k[0], k);
        check("R10 saturated", act_cnt_o, CNT_MAX);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        cyc(1, 0, 0, 0);
        check("R10 cleared", act_cnt_o, 0);

        // mixed traffic against the model
        for (int k = 0; k < 400; k++)
            cyc($urandom_range(0, 19) == 0, $urandom_range(0, 3) != 0,
                $urandom_range(0, 4) != 0, int'($urandom_range(0, 255)));

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule